// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, through two transfer paths. Each path has its own storage register and its own drive enable. A per-path select chooses what the path drives: the live value of the source bus, or the word that was last captured from that bus. Each bus pin is modelled as three vectors: an input, an output and an output enable. A small resolution stage then works out the value each bus actually carries. It does this from the transceiver's drive, from an external agent's drive and from the value the bus held before.

Capture is synchronous to the block clock. A capture strobe that is high at a clock edge stores the current resolved value of its bus. The enables and selects have no effect on capture. Suppose both paths are enabled in live mode and no external agent drives either bus. Each bus then drives the other, and the pair keeps its last value without any capture. A contention flag reports each cycle in which an external agent and the transceiver drive the same bus.

Top module: `regbus_xcvr`

## Requirements
- R1: When `cap_a` is high at a rising `clk` edge, the store for bus A takes the resolved A bus value (`a_bus`). `cap_b` does the same with `b_bus` for bus B. Both captures can happen in the same edge. Capture ignores every enable and select setting. A store keeps its word at any edge where its strobe is low.
- R2: With `sel_ab`=0, `b_out` equals the present `a_bus`. With `sel_ab`=1, `b_out` equals the stored A word. `sel_ba` works the same way for `a_out`, using `b_bus` and the stored B word. Each bit position is handled on its own.
- R3: `b_oe` is all-ones when `en_ab`=1 and all-zeros otherwise. `a_oe` is all-ones when `en_ba_n`=0 and all-zeros otherwise.
- R4: Each bus resolves in priority order. An external drive (`*_ext_drv`=1) gives `*_ext`. Failing that, a transceiver drive gives the transceiver's output. If nothing drives the bus, it keeps the value it resolved to in the previous cycle.
- R5: Suppose both paths are enabled with both selects at 0 and neither bus is driven externally. Then `a_bus` equals `b_bus` and both keep their last value across clock edges. If the two held values differ when this loop forms, both buses take the held A value.
- R6: `a_clash` is 1 exactly when `a_ext_drv`=1 and `en_ba_n`=0. `b_clash` is 1 exactly when `b_ext_drv`=1 and `en_ab`=1. While a clash lasts, the bus resolves to the external value.
- R7: Reset is synchronous and active low. A rising edge with `rst_n`=0 clears both stores and both held bus values to zero.
- R8: When a select changes, the path output goes straight from the old source's value to the new source's value within the same cycle. No intermediate value and no clock edge come in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_a | input | 1 | Capture strobe for the A-side store |
| cap_b | input | 1 | Capture strobe for the B-side store |
| en_ab | input | 1 | Active-high enable for driving bus B |
| en_ba_n | input | 1 | Active-low enable for driving bus A |
| sel_ab | input | 1 | B drive source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A drive source: 0 live B, 1 stored B |
| a_ext_drv | input | 1 | External agent drives bus A |
| a_ext | input | 8 | External value on bus A |
| b_ext_drv | input | 1 | External agent drives bus B |
| b_ext | input | 8 | External value on bus B |
| a_out | output | 8 | Transceiver output toward bus A |
| a_oe | output | 8 | Output enable for bus A pins |
| b_out | output | 8 | Transceiver output toward bus B |
| b_oe | output | 8 | Output enable for bus B pins |
| a_bus | output | 8 | Resolved value of bus A |
| b_bus | output | 8 | Resolved value of bus B |
| a_clash | output | 1 | Bus A driven by both sides |
| b_clash | output | 1 | Bus B driven by both sides |

## Verification
Some properties are checked on every cycle by the assertions:
- stores keep their word unless strobed, and take the bus value one edge after a strobe;
- an undriven bus does not move;
- both buses agree while the live loop is closed;
- a flagged clash still resolves to the external value;
- the stored path shows the store's word.

Other behaviours can only be shown by the directed scenarios:
- the loop keeping a value for many cycles after the external driver lets go;
- the held A value winning when the loop forms over differing values;
- same-cycle switching between live and stored data;
- reset clearing stores that were already loaded.

// File: rtl/regbus_xcvr_pkg.sv
// Package: shared width and path-source encoding for the registered transceiver.
// Assumes every bit lane is identical, so a single width parameter sizes everything.
package regbus_xcvr_pkg;
    localparam int XCVR_W = 8;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } path_src_e;

    // Picks the drive word of a path; a plain per-bit mux, so output changes directly.
    function automatic logic [XCVR_W-1:0] pick_src(input path_src_e src,
                                                    input logic [XCVR_W-1:0] live,
                                                    input logic [XCVR_W-1:0] stored);
        return (src == SRC_STORED) ? stored : live;
    endfunction
endpackage

// File: rtl/regbus_store.sv
// Module: one direction's storage register.
// Captures d when cap is high at a clock edge, whatever the path controls say.
// Assumes synchronous active-low reset to zero.
module regbus_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Register update: clear on reset, load on strobe, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (cap)
            q <= d;
    end

    // R1
    store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (q == $past(d)));

    // R1
    store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/regbus_resolve.sv
// Module: bus resolution stage for both sides of the transceiver.
// Works out the value each bus carries from external drive, transceiver drive
// and the previously held value. The live loop is broken without a combinational
// cycle: when both paths drive live and nothing external is present, the held A
// value feeds both buses.
// Assumes the enables arrive already decoded to active-high drive requests.
module regbus_resolve
    import regbus_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_drv,
    input  logic         b_drv,
    input  path_src_e    src_ab,
    input  path_src_e    src_ba,
    input  logic [W-1:0] store_a,
    input  logic [W-1:0] store_b,
    input  logic         a_ext_drv,
    input  logic [W-1:0] a_ext,
    input  logic         b_ext_drv,
    input  logic [W-1:0] b_ext,
    output logic [W-1:0] a_val,
    output logic [W-1:0] b_val,
    output logic [W-1:0] a_drive,
    output logic [W-1:0] b_drive
);
    logic [W-1:0] a_hold, b_hold;
    logic [W-1:0] a_pre, b_pre;

    // One-level look-ahead of each bus; a closed live loop falls back to a_hold.
    always_comb begin
        if (a_ext_drv)                a_pre = a_ext;
        else if (!a_drv)              a_pre = a_hold;
        else if (src_ba == SRC_STORED) a_pre = store_b;
        else                          a_pre = a_hold;

        if (b_ext_drv)                b_pre = b_ext;
        else if (!b_drv)              b_pre = b_hold;
        else if (src_ab == SRC_STORED) b_pre = store_a;
        else                          b_pre = a_hold;
    end

    // Final resolved value of each bus by priority: external, transceiver, held.
    always_comb begin
        if (a_ext_drv)   a_val = a_ext;
        else if (a_drv)  a_val = pick_src(src_ba, b_pre, store_b);
        else             a_val = a_hold;

        if (b_ext_drv)   b_val = b_ext;
        else if (b_drv)  b_val = pick_src(src_ab, a_pre, store_a);
        else             b_val = b_hold;
    end

    // Path outputs toward each bus, from the resolved opposite bus or the store.
    always_comb begin
        a_drive = pick_src(src_ba, b_val, store_b);
        b_drive = pick_src(src_ab, a_val, store_a);
    end

    // Held bus values: remember what each bus resolved to this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hold <= '0;
            b_hold <= '0;
        end else begin
            a_hold <= a_val;
            b_hold <= b_val;
        end
    end

    // R4
    float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !a_ext_drv && !a_drv) |-> (a_val == $past(a_val)));

    // R5
    loop_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv && b_drv && src_ab == SRC_LIVE && src_ba == SRC_LIVE) |-> (a_val == b_val));

    // R4
    a_own_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv && !a_ext_drv) |-> (a_val == a_drive));
endmodule

// File: rtl/regbus_xcvr.sv
// Module: top of the registered bidirectional bus transceiver.
// Decodes enables and selects, holds one store per direction and resolves both
// buses. Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         a_ext_drv,
    input  logic [W-1:0] a_ext,
    input  logic         b_ext_drv,
    input  logic [W-1:0] b_ext,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic [W-1:0] a_bus,
    output logic [W-1:0] b_bus,
    output logic         a_clash,
    output logic         b_clash
);
    logic         a_drv, b_drv;
    path_src_e    src_ab, src_ba;
    logic [W-1:0] store_a, store_b;

    // Control decode: polarity of enables and select encoding.
    always_comb begin
        b_drv  = en_ab;
        a_drv  = !en_ba_n;
        src_ab = path_src_e'(sel_ab);
        src_ba = path_src_e'(sel_ba);
    end

    regbus_store #(.W(W)) u_store_a (
        .clk(clk), .rst_n(rst_n), .cap(cap_a), .d(a_bus), .q(store_a)
    );

    regbus_store #(.W(W)) u_store_b (
        .clk(clk), .rst_n(rst_n), .cap(cap_b), .d(b_bus), .q(store_b)
    );

    regbus_resolve #(.W(W)) u_resolve (
        .clk(clk), .rst_n(rst_n),
        .a_drv(a_drv), .b_drv(b_drv),
        .src_ab(src_ab), .src_ba(src_ba),
        .store_a(store_a), .store_b(store_b),
        .a_ext_drv(a_ext_drv), .a_ext(a_ext),
        .b_ext_drv(b_ext_drv), .b_ext(b_ext),
        .a_val(a_bus), .b_val(b_bus),
        .a_drive(a_out), .b_drive(b_out)
    );

    // Pin enables and contention flags.
    always_comb begin
        a_oe    = {W{a_drv}};
        b_oe    = {W{b_drv}};
        a_clash = a_ext_drv && a_drv;
        b_clash = b_ext_drv && b_drv;
    end

    // R6
    a_clash_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_clash |-> (a_bus == a_ext && a_oe != '0));

    // R6
    b_clash_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_clash |-> (b_bus == b_ext && b_oe != '0));

    // R2
    stored_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ab && sel_ab && !b_ext_drv) |-> (b_bus == store_a));
endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cap_a, cap_b, en_ab, en_ba_n, sel_ab, sel_ba;
    logic       a_ext_drv, b_ext_drv;
    logic [7:0] a_ext, b_ext;
    logic [7:0] a_out, a_oe, b_out, b_oe, a_bus, b_bus;
    logic       a_clash, b_clash;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    regbus_xcvr u_regbus_xcvr (
        .clk(clk), .rst_n(rst_n), .cap_a(cap_a), .cap_b(cap_b),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_ext_drv(a_ext_drv), .a_ext(a_ext), .b_ext_drv(b_ext_drv), .b_ext(b_ext),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .a_bus(a_bus), .b_bus(b_bus), .a_clash(a_clash), .b_clash(b_clash)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Move to the next falling edge and let combinational logic settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cap_a = 0; cap_b = 0; en_ab = 0; en_ba_n = 1; sel_ab = 0; sel_ba = 0;
        a_ext_drv = 0; b_ext_drv = 0; a_ext = 8'h00; b_ext = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        step();
        step();
        rst_n = 1;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R7 a_bus", a_bus, 8'h00);
        chk("R7 b_bus", b_bus, 8'h00);
        chk("R3 a_oe off", a_oe, 8'h00);
        chk("R3 b_oe off", b_oe, 8'h00);
        en_ab = 1; sel_ab = 1; #1;
        chk("R7 store A cleared", b_out, 8'h00);
        en_ab = 0; sel_ab = 0; #1;
    endtask

    task automatic t_live_ab();
        a_ext_drv = 1; a_ext = 8'h5A; en_ab = 1; sel_ab = 0; #1;
        chk("R2 live b_out", b_out, 8'h5A);
        chk("R3 b_oe on", b_oe, 8'hFF);
        chk("R4 b_bus from xcvr", b_bus, 8'h5A);
        a_ext = 8'hA5; #1;
        chk("R2 live b_out pattern2", b_out, 8'hA5);
        step();
        a_ext_drv = 0; en_ab = 0; #1;
        chk("R4 a floats keeps last", a_bus, 8'hA5);
        step();
        chk("R4 a still held", a_bus, 8'hA5);
        chk("R4 b held after release", b_bus, 8'hA5);
    endtask

    task automatic t_store_and_select();
        a_ext_drv = 1; a_ext = 8'h3C; cap_a = 1;   // capture with enables off
        step();
        cap_a = 0; a_ext = 8'hC3; en_ab = 1; sel_ab = 1; #1;
        chk("R1 capture with path off", b_out, 8'h3C);
        sel_ab = 0; #1;
        chk("R8 switch to live same cycle", b_out, 8'hC3);
        sel_ab = 1; #1;
        chk("R8 switch to stored same cycle", b_out, 8'h3C);
        step();
        chk("R1 store kept without strobe", b_out, 8'h3C);
        a_ext_drv = 0; en_ab = 0; sel_ab = 0;
        step();
    endtask

    task automatic t_live_ba_and_dual_capture();
        a_ext_drv = 1; a_ext = 8'h81; b_ext_drv = 1; b_ext = 8'h18;
        cap_a = 1; cap_b = 1;
        step();
        cap_a = 0; cap_b = 0; a_ext_drv = 0;
        b_ext = 8'hE7; en_ba_n = 0; sel_ba = 0; #1;
        chk("R3 a_oe on", a_oe, 8'hFF);
        chk("R2 live a_out", a_out, 8'hE7);
        chk("R4 a_bus from xcvr", a_bus, 8'hE7);
        sel_ba = 1; #1;
        chk("R1 dual capture B", a_out, 8'h18);
        en_ab = 1; sel_ab = 1; #1;
        chk("R1 dual capture A", b_out, 8'h81);
        chk("R6 b clash flag", {7'd0, b_clash}, 8'h01);
        chk("R6 b clash ext wins", b_bus, 8'hE7);
        chk("R6 a no clash", {7'd0, a_clash}, 8'h00);
        a_ext_drv = 1; a_ext = 8'h42; #1;
        chk("R6 a clash flag", {7'd0, a_clash}, 8'h01);
        chk("R6 a clash ext wins", a_bus, 8'h42);
        idle_inputs();
        step();
    endtask

    task automatic t_loop_hold();
        a_ext_drv = 1; a_ext = 8'h77; en_ab = 1; en_ba_n = 0; #1;
        chk("R5 loop b follows ext a", b_bus, 8'h77);
        step();
        a_ext_drv = 0; #1;
        chk("R5 loop a held", a_bus, 8'h77);
        chk("R5 loop b held", b_bus, 8'h77);
        for (int i = 0; i < 5; i++) step();
        chk("R5 loop a after cycles", a_bus, 8'h77);
        chk("R5 loop b after cycles", b_bus, 8'h77);
        idle_inputs();
        step();
    endtask

    task automatic t_loop_differing();
        a_ext_drv = 1; a_ext = 8'h11; b_ext_drv = 1; b_ext = 8'h22;
        step();
        a_ext_drv = 0; b_ext_drv = 0; #1;
        chk("R4 b held before loop", b_bus, 8'h22);
        en_ab = 1; en_ba_n = 0; #1;
        chk("R5 A hold wins on a", a_bus, 8'h11);
        chk("R5 A hold wins on b", b_bus, 8'h11);
        step();
        chk("R5 differing loop stays", b_bus, 8'h11);
        idle_inputs();
        step();
    endtask

    task automatic t_reset_clears_loaded();
        a_ext_drv = 1; a_ext = 8'h9E; cap_a = 1;
        step();
        idle_inputs();
        do_reset();
        en_ab = 1; sel_ab = 1; #1;
        chk("R7 loaded store cleared", b_out, 8'h00);
        chk("R7 held a cleared", a_bus, 8'h00);
        idle_inputs();
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        t_reset_state();
        t_live_ab();
        t_store_and_select();
        t_live_ba_and_dual_capture();
        t_loop_hold();
        t_loop_differing();
        t_reset_clears_loaded();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule